// File: doc/BRIEF.md
# Paged SPI Register Slave

This block is the serial front end of a sensor-style device. It brings the SPI pins of an external host into the system clock domain, gathers each 16-bit frame, and turns it into a single-byte register write or a 16-bit register read on a simple bank port. Each frame starts with an address byte, whose top bit gives the direction, and ends with a data byte. The reply to a read does not come back in the frame that asked for it. It is shifted out on MISO during the host's next frame.

Two register maps share one address range. A page register held inside the block chooses between them. Every bank access carries the page that was selected when its frame arrived. The page register itself sits at one fixed address on both pages. One write command, a fixed value written to the burst-control address on page 0, also raises a one-cycle pulse that asks the data path to start a burst read.

The host runs SPI mode 3: SCLK idles high, MOSI is sampled on rising edges, MISO changes on falling edges, and data goes MSB first. CS_N must stay high for at least 10 system clocks between frames. Each SCLK phase must last at least 6 system clocks.

Top module: `spi_page_regif`

## Requirements
- R1: A complete 16-bit frame whose first byte has bit 7 set and whose low 7 bits are not 0x7E produces exactly one `reg_wr` pulse. During that pulse, `reg_addr` holds those 7 bits (even or odd), `reg_wdata` holds the second byte, and `reg_page` holds the current page.
- R2: A frame whose first byte has bit 7 clear is a read. The second byte is ignored. It produces one `reg_rd` pulse and no `reg_wr` pulse. `reg_addr` holds the 7-bit address with bit 0 forced to 0, and `reg_page` holds the current page.
- R3: The 16-bit response captured for a read is shifted out on `miso` during the next complete frame, MSB (high byte) first, one bit per SCLK falling edge.
- R4: Write frames, including page writes, leave the pending response unchanged. The frame after a write returns the same word as the frame before it.
- R5: A write frame to address 0x7E sets the page to bit 0 of its data byte (0x00 selects page 0, 0x01 selects page 1). It works from either page and is not forwarded to the bank: there is no `reg_wr` pulse.
- R6: A read of 0x7E (or 0x7F) does not pulse `reg_rd`. It makes the next frame return `{15'b0, page}`.
- R7: `burst_start` pulses for one cycle, together with the forwarded write, only when the data byte 0x80 is written to address 0x00 while page 0 is selected. Any other data value, or page 1, gives no pulse.
- R8: If CS_N rises before the 16th bit, the partial frame is dropped. There is no write, no read and no burst pulse, and the pending response and the page are kept.
- R9: After reset, page 0 is selected, the pending response is 0x0000, `miso` is high, and `reg_wr`, `reg_rd` and `burst_start` are low.
- R10: `reg_wr`, `reg_rd` and `burst_start` are single-cycle pulses, one per qualifying frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI clock from host (mode 3, idles high) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host, high while deselected |
| reg_addr | output | 7 | Register byte address for the bank access |
| reg_page | output | 1 | Page that applies to the bank access |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to write |
| reg_rd | output | 1 | One-cycle read request |
| reg_rdata | input | 16 | Bank read word, valid in the cycle of `reg_rd` |
| burst_start | output | 1 | One-cycle burst-read start pulse |

## Verification
The bank strobes come out four system clocks after the last rising SCLK edge of a frame: two synchronizer stages, the frame register, and the decode register. The bench waits a CS_N-high gap of 12 clocks before it looks at the strobe counters it keeps. A `miso` bit changes three clocks after a falling SCLK edge, so the bench reads it eight clocks after that edge, just before it raises SCLK. Read replies are checked one frame late against a bench model of the pending word and the page. An aborted frame is checked through the counters and through the reply carried by the frame that follows it.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

    localparam int FRAME_W = 16;
    localparam int ADDR_W  = 7;
    localparam int BYTE_W  = 8;

    typedef struct packed {
        logic               page;
        logic [ADDR_W-1:0]  addr;
        logic               bank_page;
        logic [BYTE_W-1:0]  wdata;
        logic               wr;
        logic               rd;
        logic               self_rd;
        logic               burst;
        logic [FRAME_W-1:0] resp;
    } cmd_state_t;

endpackage

// File: rtl/spi_regif_sync.sv
module spi_regif_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_regif_rx.sv
module spi_regif_rx
    import spi_regif_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          cs_n_s,
    input  logic          mosi_s,
    output logic          frame_vld,
    output logic [FW-1:0] frame,
    output logic          sclk_fall,
    output logic          cs_start
);
    localparam int            CNT_W = $clog2(FW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FW - 1);

    typedef struct packed {
        logic             sclk_prev;
        logic             cs_prev;
        logic [CNT_W-1:0] cnt;
        logic [FW-1:0]    shift;
        logic             vld;
        logic [FW-1:0]    frame;
    } rx_state_t;

    rx_state_t rx_d, rx_q;

    always_comb begin
        rx_d           = rx_q;
        rx_d.vld       = 1'b0;
        rx_d.sclk_prev = sclk_s;
        rx_d.cs_prev   = cs_n_s;
        if (cs_n_s) begin
            rx_d.cnt   = '0;
            rx_d.shift = '0;
        end else if (sclk_s && !rx_q.sclk_prev) begin
            rx_d.shift = {rx_q.shift[FW-2:0], mosi_s};
            if (rx_q.cnt == LAST) begin
                rx_d.vld   = 1'b1;
                rx_d.frame = rx_d.shift;
                rx_d.cnt   = '0;
            end else begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q           <= '0;
            rx_q.sclk_prev <= 1'b1;
            rx_q.cs_prev   <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign frame_vld = rx_q.vld;
    assign frame     = rx_q.frame;
    assign sclk_fall = !cs_n_s && !sclk_s && rx_q.sclk_prev;
    assign cs_start  = rx_q.cs_prev && !cs_n_s;

    // R8
    abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !frame_vld);
endmodule

// File: rtl/spi_regif_cmd.sv
module spi_regif_cmd
    import spi_regif_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PAGE_ADDR  = 7'h7E,
    parameter logic [ADDR_W-1:0] BURST_ADDR = 7'h00,
    parameter logic [BYTE_W-1:0] BURST_CMD  = 8'h80,
    parameter logic              BURST_PAGE = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_vld,
    input  logic [FRAME_W-1:0] frame,
    input  logic [FRAME_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0]  reg_addr,
    output logic               reg_page,
    output logic               reg_wr,
    output logic [BYTE_W-1:0]  reg_wdata,
    output logic               reg_rd,
    output logic               burst_start,
    output logic [FRAME_W-1:0] resp
);
    cmd_state_t cm_d, cm_q;
    logic [BYTE_W-1:0] hdr, dat;
    logic [ADDR_W-1:0] word_addr;

    assign hdr       = frame[FRAME_W-1:BYTE_W];
    assign dat       = frame[BYTE_W-1:0];
    assign word_addr = {hdr[ADDR_W-1:1], 1'b0};

    always_comb begin
        cm_d         = cm_q;
        cm_d.wr      = 1'b0;
        cm_d.rd      = 1'b0;
        cm_d.self_rd = 1'b0;
        cm_d.burst   = 1'b0;
        if (cm_q.rd)      cm_d.resp = reg_rdata;
        if (cm_q.self_rd) cm_d.resp = {{(FRAME_W-1){1'b0}}, cm_q.page};
        if (frame_vld) begin
            if (hdr[BYTE_W-1]) begin
                if (hdr[ADDR_W-1:0] == PAGE_ADDR) begin
                    cm_d.page = dat[0];
                end else begin
                    cm_d.wr        = 1'b1;
                    cm_d.addr      = hdr[ADDR_W-1:0];
                    cm_d.bank_page = cm_q.page;
                    cm_d.wdata     = dat;
                    cm_d.burst     = (hdr[ADDR_W-1:0] == BURST_ADDR) &&
                                     (dat == BURST_CMD) &&
                                     (cm_q.page == BURST_PAGE);
                end
            end else if (word_addr == {PAGE_ADDR[ADDR_W-1:1], 1'b0}) begin
                cm_d.self_rd = 1'b1;
            end else begin
                cm_d.rd        = 1'b1;
                cm_d.addr      = word_addr;
                cm_d.bank_page = cm_q.page;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cm_q <= '0;
        else        cm_q <= cm_d;
    end

    assign reg_addr    = cm_q.addr;
    assign reg_page    = cm_q.bank_page;
    assign reg_wr      = cm_q.wr;
    assign reg_wdata   = cm_q.wdata;
    assign reg_rd      = cm_q.rd;
    assign burst_start = cm_q.burst;
    assign resp        = cm_q.resp;

    // R10
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    // R10
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);
    // R2
    rd_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> !reg_addr[0]);
    // R2
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));
    // R5
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> $stable(cm_q.page));
    // R7
    burst_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |-> (reg_wr && reg_wdata == BURST_CMD && reg_page == BURST_PAGE));
    // R4
    resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd && !cm_q.self_rd) |=> $stable(resp));
endmodule

// File: rtl/spi_regif_tx.sv
module spi_regif_tx
    import spi_regif_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_s,
    input  logic          cs_start,
    input  logic          sclk_fall,
    input  logic [FW-1:0] resp,
    output logic          miso
);
    typedef struct packed {
        logic [FW-1:0] shift;
        logic          bit_out;
    } tx_state_t;

    tx_state_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (cs_n_s) begin
            tx_d.bit_out = 1'b1;
        end else if (cs_start) begin
            tx_d.shift = resp;
        end else if (sclk_fall) begin
            tx_d.bit_out = tx_q.shift[FW-1];
            tx_d.shift   = {tx_q.shift[FW-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q         <= '0;
            tx_q.bit_out <= 1'b1;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign miso = tx_q.bit_out;

    // R9
    miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> miso);
    // R3
    miso_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && !sclk_fall) |=> $stable(miso));
endmodule

// File: rtl/spi_page_regif.sv
module spi_page_regif
    import spi_regif_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] PAGE_ADDR   = 7'h7E,
    parameter logic [ADDR_W-1:0] BURST_ADDR  = 7'h00,
    parameter logic [BYTE_W-1:0] BURST_CMD   = 8'h80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               mosi,
    output logic               miso,
    output logic [ADDR_W-1:0]  reg_addr,
    output logic               reg_page,
    output logic               reg_wr,
    output logic [BYTE_W-1:0]  reg_wdata,
    output logic               reg_rd,
    input  logic [FRAME_W-1:0] reg_rdata,
    output logic               burst_start
);
    logic [2:0]         pins_s;
    logic               frame_vld, sclk_fall, cs_start;
    logic [FRAME_W-1:0] frame, resp;

    spi_regif_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({sclk, cs_n, mosi}), .q(pins_s));

    spi_regif_rx u_rx (
        .clk(clk), .rst_n(rst_n), .sclk_s(pins_s[2]), .cs_n_s(pins_s[1]),
        .mosi_s(pins_s[0]), .frame_vld(frame_vld), .frame(frame),
        .sclk_fall(sclk_fall), .cs_start(cs_start));

    spi_regif_cmd #(.PAGE_ADDR(PAGE_ADDR), .BURST_ADDR(BURST_ADDR),
                    .BURST_CMD(BURST_CMD), .BURST_PAGE(1'b0)) u_cmd (
        .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame(frame),
        .reg_rdata(reg_rdata), .reg_addr(reg_addr), .reg_page(reg_page),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
        .burst_start(burst_start), .resp(resp));

    spi_regif_tx u_tx (
        .clk(clk), .rst_n(rst_n), .cs_n_s(pins_s[1]), .cs_start(cs_start),
        .sclk_fall(sclk_fall), .resp(resp), .miso(miso));
endmodule

// File: tb/spi_page_regif_tb.sv
`timescale 1ns/1ps
module spi_page_regif_tb;
    localparam int HALF = 8;
    localparam int GAP  = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
    logic miso, reg_page, reg_wr, reg_rd, burst_start;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [15:0] reg_rdata;

    int errs = 0, checks = 0;
    bit done = 0;
    int wr_cnt = 0, rd_cnt = 0, bu_cnt = 0;
    logic [6:0] lw_addr, lr_addr;
    logic lw_page, lr_page;
    logic [7:0] lw_data;
    logic [15:0] exp_resp = 16'h0;
    logic exp_page = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] bank_word(input logic pg, input logic [6:0] a);
        return {pg, a, ~a, ~pg};
    endfunction

    assign reg_rdata = bank_word(reg_page, reg_addr);

    spi_page_regif u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .reg_addr(reg_addr), .reg_page(reg_page), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .burst_start(burst_start));

    always @(posedge clk) begin
        if (reg_wr) begin
            wr_cnt  <= wr_cnt + 1;
            lw_addr <= reg_addr; lw_page <= reg_page; lw_data <= reg_wdata;
        end
        if (reg_rd) begin
            rd_cnt  <= rd_cnt + 1;
            lr_addr <= reg_addr; lr_page <= reg_page;
        end
        if (burst_start) bu_cnt <= bu_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] a, input logic [7:0] d, input int nbits,
                        output logic [15:0] rx);
        logic [15:0] tx;
        tx = {a, d};
        rx = '0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            mosi = tx[15-i];
            repeat (HALF) @(negedge clk);
            rx[15-i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] a, input logic [7:0] d, input int nbits);
        int w0, r0, b0;
        logic [15:0] rx;
        logic [6:0] wa;
        w0 = wr_cnt; r0 = rd_cnt; b0 = bu_cnt;
        xfer(a, d, nbits, rx);
        if (nbits < 16) begin
            chk("R8 writes after abort", wr_cnt, w0);
            chk("R8 reads after abort", rd_cnt, r0);
            chk("R8 bursts after abort", bu_cnt, b0);
            return;
        end
        chk("R3 reply word", rx, exp_resp);
        if (a[7]) begin
            if (a[6:0] == 7'h7E) begin
                exp_page = d[0];
                chk("R5 page write not forwarded", wr_cnt, w0);
            end else begin
                chk("R1 one write pulse", wr_cnt, w0 + 1);
                chk("R1 write fields", {lw_page, lw_addr, lw_data}, {exp_page, a[6:0], d});
                chk("R7 burst count", bu_cnt,
                    b0 + ((a[6:0] == 7'h00 && d == 8'h80 && !exp_page) ? 1 : 0));
            end
            chk("R4 no read on write", rd_cnt, r0);
        end else begin
            wa = {a[6:1], 1'b0};
            chk("R2 no write on read", wr_cnt, w0);
            if (wa == 7'h7E) begin
                chk("R6 page read not forwarded", rd_cnt, r0);
                exp_resp = {15'b0, exp_page};
            end else begin
                chk("R2 one read pulse", rd_cnt, r0 + 1);
                chk("R2 read address and page", {lr_page, lr_addr}, {exp_page, wa});
                exp_resp = bank_word(exp_page, wa);
            end
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=expired expected=done");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R9 reset state
        chk("R9 miso idle", miso, 1'b1);
        chk("R9 strobes low", {reg_wr, reg_rd, burst_start}, 3'b000);
        frame(8'h02, 8'hFF, 16);        // R9 first reply is zero
        frame(8'h82, 8'h55, 16);        // R1 write on page 0
        frame(8'h83, 8'hAA, 16);        // R1 odd write, R4 reply kept
        frame(8'h13, 8'h00, 16);        // R2 odd read
        frame(8'hFE, 8'h01, 16);        // R5 select page 1
        frame(8'h7E, 8'h00, 16);        // R6 read page
        frame(8'h02, 8'h00, 16);        // R6 reply 1, R2 on page 1
        frame(8'h80, 8'h80, 16);        // R7 no burst on page 1
        frame(8'hFE, 8'h00, 16);        // R5 back to page 0
        frame(8'h80, 8'h80, 16);        // R7 burst
        frame(8'h80, 8'h81, 16);        // R7 other data, no burst
        frame(8'h44, 8'h00, 16);        // read to load reply
        frame(8'h85, 8'h12, 7);         // R8 abort
        frame(8'h7F, 8'h00, 16);        // R8 reply kept, R6 odd page read
        frame(8'hFE, 8'h01, 9);         // R8 aborted page write
        frame(8'h00, 8'h00, 16);        // R8 page still 0
        for (int n = 0; n < 70; n++) begin
            logic [7:0] a, d;
            int nb;
            a  = 8'($urandom);
            d  = ($urandom % 4 == 0) ? 8'h80 : 8'($urandom);
            if ($urandom % 6 == 0) a = {a[7], 7'h7E};
            if ($urandom % 8 == 0) a = {a[7], 7'h00};
            nb = ($urandom % 8 == 0) ? 1 + ($urandom % 15) : 16;
            frame(a, d, nb);
        end
        frame(8'h00, 8'h00, 16);
        done = 1;
        summary();
    end
endmodule